// File: doc/BRIEF.md
# Block-Oriented Address Sequence Generator

This block produces a stream of 24-bit addresses, one per clock, arranged as a run of blocks. A start pulse loads the first address. Each later address inside a block adds a per-address step to the previous one. Each new block begins at the previous block's first address plus a block step. The length of a block and the number of blocks are parameters. Typical uses are sub-image scans, where a block is one row, and serial counts that a later bit-remap stage turns into FFT addressing.

Three run modes are available. One-shot stops at the end of the sequence and holds the last address. Restart begins a new sequence straight after the last address. Continuous never ends. A split mode blocks the carry between the low and high 12-bit halves of the adder, so the two halves count as two independent sequences.

A block-hold input can freeze generation at any block boundary. At the end of the final block in restart mode, it also holds off the restart. The step, block step and split setting are captured when a sequence is loaded. The size, count and mode are captured at the same moment. New settings can therefore be presented while a sequence runs.

Top module: `addr_seq_gen`

## Requirements
- R1: A start pulse seen high on a clock edge places `start_addr` on `addr_out` after that edge. The same value becomes the current block's first address. A start pulse arriving during a running sequence aborts it and starts a new sequence in the same way (R10).
- R2: Inside a block, each clock adds the captured `addr_step` to `addr_out`. A block holds exactly `blk_size` addresses, and a `blk_size` of 0 is treated as 1.
- R3: `blk_done_n` is low exactly while the last address of a block is on `addr_out`. On the next clock, `addr_out` becomes the block's first address plus the captured `blk_step`, and that value becomes the new block start.
- R4: A sequence consists of `num_blks` blocks, and a `num_blks` of 0 is treated as 1. `seq_done_n` is low only while the final address of the final block is on `addr_out`, and `blk_done_n` is low during that same cycle.
- R5: Mode 2'b00 is one-shot. After the final address, `addr_out` holds that address. From the next cycle on, both flags are high, and this state lasts until a new start pulse.
- R6: Mode 2'b01 is restart. While the final address is on `addr_out` and `blk_hold` is low, `restart_req` is high. On the next clock, `addr_out` becomes `start_addr` with no gap, and the new sequence runs with the parameters then present.
- R7: Mode 2'b10 or 2'b11 is continuous. `num_blks` is ignored, `seq_done_n` stays high, and blocks follow one another without end.
- R8: When `dual_en` is captured as 1, no carry passes from bit 11 into bit 12. Each 12-bit half then steps and wraps modulo 4096 on its own.
- R9: If `blk_hold` is high at a block boundary, `addr_out` and `blk_done_n` keep their values until `blk_hold` goes low. At the end of the final block in restart mode, `blk_hold` high keeps `restart_req` low and holds the final address.
- R10: A start pulse during an active sequence discards the current block and block counts and reloads from the present inputs.
- R11: After a synchronous reset, `addr_out` is 0, `blk_done_n` and `seq_done_n` are 1, `restart_req` is 0, and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_pulse | input | 1 | One-cycle start request, active high |
| blk_hold | input | 1 | Freeze at block boundaries, active high |
| mode | input | 2 | 00 one-shot, 01 restart, 1x continuous |
| dual_en | input | 1 | Split the adder into two 12-bit halves |
| start_addr | input | 24 | First address of a sequence |
| blk_size | input | 24 | Addresses per block |
| addr_step | input | 24 | Step between addresses in a block |
| num_blks | input | 24 | Blocks per sequence |
| blk_step | input | 24 | Step between block start addresses |
| addr_out | output | 24 | Current address |
| blk_done_n | output | 1 | Low on the last address of a block |
| seq_done_n | output | 1 | Low on the last address of a sequence |
| restart_req | output | 1 | High when restart mode is about to reload |

## Verification
The address is a registered output. It changes one edge after the start pulse, restart or step that caused it. The two done flags are decoded from registered state, so they change on the same edge as the address they describe. `restart_req` also reacts within the same cycle to `blk_hold`.

The bench changes inputs one nanosecond after a rising edge and samples one nanosecond after the next edge. Sample k after a start is therefore compared with the k-th address of the expected sequence. The expected values come from a closed-form function of the block index and the in-block index. A hold check samples again at the same position after each frozen edge.

// File: rtl/seqgen_pkg.sv
package seqgen_pkg;

    localparam int SEQ_ADDR_W = 24;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2,
        OP_NEXT = 2'd3
    } seq_op_e;

    localparam logic [1:0] MODE_ONESHOT = 2'b00;
    localparam logic [1:0] MODE_RESTART = 2'b01;

    typedef struct packed {
        logic active;
        logic last_in_blk;
        logic last_blk;
    } seq_state_t;

endpackage

// File: rtl/seqgen_ctrl.sv
module seqgen_ctrl
    import seqgen_pkg::*;
#(
    parameter int AW = SEQ_ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_pulse,
    input  logic          blk_hold,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] blk_size,
    input  logic [AW-1:0] num_blks,
    output seq_op_e       op,
    output logic          blk_done_n,
    output logic          seq_done_n,
    output logic          restart_req
);

    function automatic logic [AW-1:0] cnt_init(input logic [AW-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    logic [AW-1:0] in_cnt_q, blk_cnt_q, szm1_q;
    logic [1:0]    mode_q;
    logic          active_q;
    logic          cont;
    seq_state_t    st;

    assign cont           = mode_q[1];
    assign st.active      = active_q;
    assign st.last_in_blk = (in_cnt_q == '0);
    assign st.last_blk    = (blk_cnt_q == '0) && !cont;

    always_comb begin
        op = OP_HOLD;
        if (start_pulse) begin
            op = OP_LOAD;
        end else if (st.active) begin
            if (!st.last_in_blk) begin
                op = OP_STEP;
            end else if (st.last_blk) begin
                if (mode_q == MODE_RESTART && !blk_hold) op = OP_LOAD;
            end else if (!blk_hold) begin
                op = OP_NEXT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q  <= 1'b0;
            in_cnt_q  <= '0;
            blk_cnt_q <= '0;
            szm1_q    <= '0;
            mode_q    <= MODE_ONESHOT;
        end else begin
            case (op)
                OP_LOAD: begin
                    active_q  <= 1'b1;
                    in_cnt_q  <= cnt_init(blk_size);
                    szm1_q    <= cnt_init(blk_size);
                    blk_cnt_q <= cnt_init(num_blks);
                    mode_q    <= mode;
                end
                OP_STEP: in_cnt_q <= in_cnt_q - 1'b1;
                OP_NEXT: begin
                    in_cnt_q <= szm1_q;
                    if (!cont) blk_cnt_q <= blk_cnt_q - 1'b1;
                end
                default: begin
                    if (st.active && st.last_in_blk && st.last_blk &&
                        mode_q == MODE_ONESHOT)
                        active_q <= 1'b0;
                end
            endcase
        end
    end

    assign blk_done_n  = !(st.active && st.last_in_blk);
    assign seq_done_n  = !(st.active && st.last_in_blk && st.last_blk);
    assign restart_req = st.active && st.last_in_blk && st.last_blk &&
                         (mode_q == MODE_RESTART) && !blk_hold;

    // R2: the in-block counter never exceeds the captured block length
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (in_cnt_q <= szm1_q));

    // R5: one-shot releases both flags on the cycle after the final address
    a_r5_halt_releases: assert property (@(posedge clk) disable iff (rst)
        (!seq_done_n && mode_q == MODE_ONESHOT && !start_pulse) |=>
        (blk_done_n && seq_done_n));

endmodule

// File: rtl/seqgen_datapath.sv
module seqgen_datapath
    import seqgen_pkg::*;
#(
    parameter int AW = SEQ_ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_op_e       op,
    input  logic          dual_en,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] addr_step,
    input  logic [AW-1:0] blk_step,
    output logic [AW-1:0] addr_q
);

    localparam int HW = AW / 2;
    localparam int UW = AW - HW;

    function automatic logic [AW-1:0] split_add(input logic [AW-1:0] a,
                                                input logic [AW-1:0] b,
                                                input logic          split);
        logic [HW:0]   lo;
        logic [UW-1:0] hi;
        lo = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]};
        hi = a[AW-1:HW] + b[AW-1:HW] + {{(UW-1){1'b0}}, lo[HW] & ~split};
        return {hi, lo[HW-1:0]};
    endfunction

    logic [AW-1:0] blk_base_q, step_q, bstep_q, base, inc, sum;
    logic          dual_q;

    assign base = (op == OP_NEXT) ? blk_base_q : addr_q;
    assign inc  = (op == OP_NEXT) ? bstep_q    : step_q;
    assign sum  = split_add(base, inc, dual_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q     <= '0;
            blk_base_q <= '0;
            step_q     <= '0;
            bstep_q    <= '0;
            dual_q     <= 1'b0;
        end else begin
            case (op)
                OP_LOAD: begin
                    addr_q     <= start_addr;
                    blk_base_q <= start_addr;
                    step_q     <= addr_step;
                    bstep_q    <= blk_step;
                    dual_q     <= dual_en;
                end
                OP_STEP: addr_q <= sum;
                OP_NEXT: begin
                    addr_q     <= sum;
                    blk_base_q <= sum;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/addr_seq_gen.sv
module addr_seq_gen
    import seqgen_pkg::*;
#(
    parameter int AW = SEQ_ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_pulse,
    input  logic          blk_hold,
    input  logic [1:0]    mode,
    input  logic          dual_en,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] blk_size,
    input  logic [AW-1:0] addr_step,
    input  logic [AW-1:0] num_blks,
    input  logic [AW-1:0] blk_step,
    output logic [AW-1:0] addr_out,
    output logic          blk_done_n,
    output logic          seq_done_n,
    output logic          restart_req
);

    seq_op_e op;

    seqgen_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_pulse(start_pulse),
        .blk_hold   (blk_hold),
        .mode       (mode),
        .blk_size   (blk_size),
        .num_blks   (num_blks),
        .op         (op),
        .blk_done_n (blk_done_n),
        .seq_done_n (seq_done_n),
        .restart_req(restart_req)
    );

    seqgen_datapath #(.AW(AW)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .dual_en   (dual_en),
        .start_addr(start_addr),
        .addr_step (addr_step),
        .blk_step  (blk_step),
        .addr_q    (addr_out)
    );

    // R1: a start pulse places the start address on the output after the edge
    a_r1_start_loads: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> (addr_out == $past(start_addr)));

    // R6: a restart request reloads the start address with no gap
    a_r6_restart_reloads: assert property (@(posedge clk) disable iff (rst)
        (restart_req && !start_pulse) |=> (addr_out == $past(start_addr)));

    // R9: a hold at an inner block boundary freezes the address and the flag
    a_r9_hold_freezes: assert property (@(posedge clk) disable iff (rst)
        (!blk_done_n && seq_done_n && blk_hold && !start_pulse) |=>
        ($stable(addr_out) && !blk_done_n));

endmodule

// File: tb/test_addr_seq_gen.sv
module test_addr_seq_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_pulse = 1'b0, blk_hold = 1'b0, dual_en = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [23:0] start_addr = '0, blk_size = 24'd1, addr_step = '0;
    logic [23:0] num_blks = 24'd1, blk_step = '0;
    logic [23:0] addr_out;
    logic        blk_done_n, seq_done_n, restart_req;

    int checks = 0;
    int errors = 0;

    logic [23:0] g_st, g_stp, g_bst;
    int          g_sz, g_n;
    logic [1:0]  g_md;
    logic        g_dual;

    addr_seq_gen i_addr_seq_gen (
        .clk(clk), .rst(rst), .start_pulse(start_pulse), .blk_hold(blk_hold),
        .mode(mode), .dual_en(dual_en), .start_addr(start_addr),
        .blk_size(blk_size), .addr_step(addr_step), .num_blks(num_blks),
        .blk_step(blk_step), .addr_out(addr_out), .blk_done_n(blk_done_n),
        .seq_done_n(seq_done_n), .restart_req(restart_req)
    );

    always #2 clk = ~clk;

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual still running, expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_addr(int k);
        longint b, i, lo, hi;
        b = k / g_sz;
        i = k % g_sz;
        if (!g_dual)
            return 24'(longint'(g_st) + b * longint'(g_bst) + i * longint'(g_stp));
        lo = longint'(g_st[11:0]) + b * longint'(g_bst[11:0]) + i * longint'(g_stp[11:0]);
        hi = longint'(g_st[23:12]) + b * longint'(g_bst[23:12]) + i * longint'(g_stp[23:12]);
        return {12'(hi), 12'(lo)};
    endfunction

    task automatic setup(logic [23:0] st, logic [23:0] sz, logic [23:0] stp,
                         logic [23:0] n, logic [23:0] bst, logic [1:0] md,
                         logic dual);
        start_addr = st; blk_size = sz; addr_step = stp; num_blks = n;
        blk_step = bst; mode = md; dual_en = dual;
        g_st = st; g_stp = stp; g_bst = bst; g_md = md; g_dual = dual;
        g_sz = (sz == 0) ? 1 : int'(sz);
        g_n  = (n == 0) ? 1 : int'(n);
    endtask

    task automatic check_k(int k, string tag);
        int p, kk;
        logic ebd, edn, err;
        p   = g_sz * g_n;
        kk  = (g_md == 2'b01) ? (k % p) : k;
        ebd = ((kk % g_sz) == g_sz - 1);
        edn = g_md[1] ? 1'b0 : (kk == p - 1);
        err = (g_md == 2'b01) && edn && !blk_hold;
        chk({tag, " addr"}, addr_out, exp_addr(kk));
        chk({tag, " blk_done_n"}, {23'd0, blk_done_n}, {23'd0, !ebd});
        chk({tag, " seq_done_n"}, {23'd0, seq_done_n}, {23'd0, !edn});
        chk({tag, " restart_req"}, {23'd0, restart_req}, {23'd0, err});
    endtask

    task automatic go;
        start_pulse = 1'b1;
        tick();
        start_pulse = 1'b0;
    endtask

    task automatic run(int cycles, string tag);
        go();
        check_k(0, tag);
        for (int k = 1; k < cycles; k++) begin
            tick();
            check_k(k, tag);
        end
    endtask

    task automatic check_halted(string tag);
        logic [23:0] last;
        last = exp_addr(g_sz * g_n - 1);
        for (int j = 0; j < 3; j++) begin
            tick();
            chk({tag, " held addr"}, addr_out, last);
            chk({tag, " flags released"}, {22'd0, blk_done_n, seq_done_n}, 24'd3);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        tick(); tick();
        // R11: reset state
        chk("R11 addr", addr_out, 24'd0);
        chk("R11 flags", {21'd0, blk_done_n, seq_done_n, restart_req}, 24'd6);
        rst = 1'b0;
        tick();

        // R1 R2 R3 R4 R5: sub-image scan, one-shot
        setup(24'd35, 24'd8, 24'd1, 24'd8, 24'd16, 2'b00, 1'b0);
        run(64, "R3 subimage");
        check_halted("R5 subimage");

        // R2 R4: zero size and zero count act as one
        setup(24'h123456, 24'd0, 24'd7, 24'd0, 24'd9, 2'b00, 1'b0);
        run(1, "R4 zero size");
        check_halted("R2 zero size");

        // R2 R3 R4: random one-shot runs
        for (int r = 0; r < 8; r++) begin
            setup(24'($urandom), 24'($urandom_range(1, 5)), 24'($urandom),
                  24'($urandom_range(1, 4)), 24'($urandom), 2'b00,
                  1'($urandom_range(0, 1)));
            run(g_sz * g_n, "R2 random");
            check_halted("R5 random");
        end

        // R8: halves wrap on their own
        setup(24'hFFEFFE, 24'd3, 24'h001001, 24'd2, 24'h003003, 2'b00, 1'b1);
        run(6, "R8 dual");
        check_halted("R8 dual");
        setup(24'h000FFE, 24'd4, 24'h000001, 24'd1, 24'd0, 2'b00, 1'b0);
        run(4, "R8 carry");

        // R6: restart mode runs back to back
        setup(24'd500, 24'd3, 24'd2, 24'd2, 24'd100, 2'b01, 1'b0);
        run(20, "R6 restart");

        // R7: continuous ignores the block count
        setup(24'd10, 24'd2, 24'd3, 24'd1, 24'd50, 2'b10, 1'b0);
        run(25, "R7 continuous");
        setup(24'd7, 24'd3, 24'd1, 24'd2, 24'd5, 2'b11, 1'b0);
        run(12, "R7 continuous b");

        // R9: hold at an inner block boundary
        setup(24'd1000, 24'd3, 24'd1, 24'd3, 24'd10, 2'b00, 1'b0);
        run(3, "R9 pre");
        blk_hold = 1'b1;
        for (int j = 0; j < 3; j++) begin
            tick();
            check_k(2, "R9 hold");
        end
        blk_hold = 1'b0;
        for (int k = 3; k < 9; k++) begin
            tick();
            check_k(k, "R9 after");
        end
        check_halted("R9 end");

        // R9 R6: hold delays the restart
        setup(24'd77, 24'd2, 24'd1, 24'd2, 24'd4, 2'b01, 1'b0);
        run(4, "R6 pre");
        blk_hold = 1'b1;
        #0;
        chk("R9 restart_req held", {23'd0, restart_req}, 24'd0);
        for (int j = 0; j < 2; j++) begin
            tick();
            check_k(3, "R9 restart hold");
        end
        blk_hold = 1'b0;
        #0;
        chk("R6 restart_req", {23'd0, restart_req}, 24'd1);
        tick();
        check_k(0, "R6 reload");

        // R10: abort mid sequence
        setup(24'd100, 24'd4, 24'd1, 24'd2, 24'd20, 2'b00, 1'b0);
        run(3, "R10 first");
        setup(24'd5000, 24'd2, 24'd3, 24'd2, 24'd40, 2'b00, 1'b0);
        run(4, "R10 abort");
        check_halted("R10 end");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule